// File: doc/BRIEF.md
# SDLC Loop Secondary Station Controller

This block is the line-side controller of one secondary station on an SDLC loop. It runs on a system clock, and a one-cycle bit-clock enable marks each bit time. While it is on the loop, the station repeats the raw receive line onto the transmit line one bit time late, so that traffic reaches the stations further along the loop. It also watches the decoded receive stream for an end-of-poll (EOP) pattern.

When an EOP arrives and the station is armed and allowed to go active, it takes over the transmit line. It sends an opening flag, then the frame body from a ready/valid bit source, then a closing flag, and then falls back to repeating. The body arrives already zero-stuffed and with its CRC appended. In NRZI mode the controller decodes the receive line, encodes what it sends, and adds an extra zero after the closing flag when that is needed to bring the two lines to the same level. Clearing loop enable takes the station off the loop without breaking a frame that is in progress. Off the loop, the station idles with either marks or flags.

Top module: `sdlc_loop_station`

## Requirements
- R1: While repeating, the transmit line after each bit-enable edge equals the raw receive line sampled at that edge, which is a delay of exactly one bit time.
- R2: An EOP is a decoded 0 followed by seven decoded 1s. When an EOP completes while the station is repeating, armed, and go-active is set, the next bit times carry the opening flag 01111110, then the body bits, then the closing flag 01111110, and then repeating resumes.
- R3: The loop-sending status is high from the bit edge that starts the opening flag until the frame, including any extra zero, has been sent. It is low at every other time.
- R4: The station is disarmed when it joins the loop, and also when an EOP completes while go-active is clear. It becomes armed again only after a decoded flag 01111110 has been received. A disarmed station repeats an EOP and does not transmit.
- R5: The body-ready output is high only while body bits are being sent. One body bit is taken on each bit enable while the bit is valid, and a valid bit flagged last is followed by the closing flag. A bit time with no valid bit sends a 1.
- R6: Clearing loop enable while a frame is being sent lets the frame finish through its closing flag (and any extra zero) before the station goes off the loop. Clearing it while repeating takes the station off the loop at the next bit enable. On-loop is low whenever the station is off the loop. If loop enable is cleared in the same bit time as a takeover EOP, the station goes off the loop and does not transmit.
- R7: While off the loop with loop enable set, a completed EOP puts the station on the loop, in repeating mode, at that bit edge.
- R8: With NRZI enabled, a decoded 0 is a change of line level and a decoded 1 is a held level, for both receive and transmit. Repeating copies raw line levels.
- R9: In NRZI mode, if the line level after the final zero of the closing flag differs from the receive line, one extra zero is sent before repeating resumes.
- R10: Off the loop, the transmit line sends continuous 1s when mark idle is set, and back-to-back 01111110 flags otherwise. Both are encoded as in R8.
- R11: After reset the station is off the loop, the transmit line is 1, and on-loop, loop-sending and body-ready are low.
- R12: Outputs change only on clock edges where the bit enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitEn | input | 1 | One-cycle strobe marking a bit time |
| rxLine | input | 1 | Raw receive line level |
| cfgLoopEn | input | 1 | Loop mode enable |
| cfgGoActive | input | 1 | Allow transmission on the next EOP |
| cfgNrzi | input | 1 | NRZI line coding enable |
| cfgMarkIdle | input | 1 | Off-loop idle: 1 = marks, 0 = flags |
| bodyValid | input | 1 | Body bit valid |
| bodyBit | input | 1 | Body bit value |
| bodyLast | input | 1 | Marks the final body bit |
| bodyReady | output | 1 | Station is consuming body bits |
| txLine | output | 1 | Transmit line level |
| onLoop | output | 1 | Station is on the loop |
| loopSending | output | 1 | Station is sending its own frame |

## Verification
Two events can coincide in a single bit time: the EOP that would start a takeover and the clearing of loop enable. The bench drives the last EOP bit with loop enable already low. It then expects on-loop to drop and loop-sending to stay low, so the exit must win over the takeover. A second overlap occurs when loop enable is cleared in the middle of a frame body, and there the frame must still run through its closing flag. The cycle-by-cycle model judges both cases, and it is also used to confirm that NRZI frames with both zero-count parities produce the extra zero exactly when R9 calls for it.

// File: rtl/sdlc_loop_pkg.sv
package sdlc_loop_pkg;
  localparam int PAT_W = 8;
  localparam int CNT_W = $clog2(PAT_W);
  localparam logic [PAT_W-1:0] FLAG_PAT = 8'b0111_1110;
  localparam logic [PAT_W-1:0] EOP_PAT  = 8'b0111_1111;

  typedef enum logic [2:0] {
    ST_OFF, ST_REPEAT, ST_OPEN, ST_BODY, ST_CLOSE, ST_EXTRA
  } loopState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic repeatSel;   // copy raw receive level to the transmit line
    logic sendBit;     // decoded bit to encode when not repeating
  } txStrobe_t;
endpackage

// File: rtl/sdlc_loop_dp.sv
module sdlc_loop_dp
  import sdlc_loop_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic       rxLine,
  input  logic       nrziEn,
  input  txStrobe_t  strb,
  output logic       txLine,
  output logic       eopSeen,
  output logic       flagSeen,
  output logic       levelMismatch
);
  logic             rxPrev;
  logic [PAT_W-1:0] win;
  logic [PAT_W-1:0] winNext;
  logic             decBit;
  logic             encLevel;
  logic             txNext;

  // receive decode: NRZI zero is a level change
  assign decBit   = nrziEn ? (rxLine == rxPrev) : rxLine;
  assign winNext  = {win[PAT_W-2:0], decBit};
  assign eopSeen  = (winNext == EOP_PAT);
  assign flagSeen = (winNext == FLAG_PAT);

  // transmit encode
  assign encLevel      = nrziEn ? (strb.sendBit ? txLine : ~txLine) : strb.sendBit;
  assign txNext        = strb.repeatSel ? rxLine : encLevel;
  assign levelMismatch = (encLevel != rxLine);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxPrev <= 1'b1;
      win    <= '1;
      txLine <= 1'b1;
    end else if (bitEn) begin
      rxPrev <= rxLine;
      win    <= winNext;
      txLine <= txNext;
    end
  end
endmodule

// File: rtl/sdlc_loop_ctrl.sv
module sdlc_loop_ctrl
  import sdlc_loop_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic       cfgLoopEn,
  input  logic       cfgGoActive,
  input  logic       cfgNrzi,
  input  logic       cfgMarkIdle,
  input  logic       bodyValid,
  input  logic       bodyBit,
  input  logic       bodyLast,
  input  logic       eopSeen,
  input  logic       flagSeen,
  input  logic       levelMismatch,
  output txStrobe_t  strb,
  output logic       bodyReady,
  output logic       onLoop,
  output logic       loopSending
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PAT_W - 1);

  loopState_t       state, stNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic             armed, armedNext;
  logic             flagBit;
  logic             cntWrap;
  loopState_t       leaveState;

  assign cntWrap    = (cnt == CNT_LAST);
  assign flagBit    = (cnt != '0) && !cntWrap;
  assign leaveState = cfgLoopEn ? ST_REPEAT : ST_OFF;

  always_comb begin
    strb.repeatSel = 1'b0;
    strb.sendBit   = 1'b1;
    unique case (state)
      ST_OFF:    strb.sendBit   = cfgMarkIdle ? 1'b1 : flagBit;
      ST_REPEAT: strb.repeatSel = 1'b1;
      ST_OPEN,
      ST_CLOSE:  strb.sendBit   = flagBit;
      ST_BODY:   strb.sendBit   = bodyValid ? bodyBit : 1'b1;
      ST_EXTRA:  strb.sendBit   = 1'b0;
      default:   strb.sendBit   = 1'b1;
    endcase
  end

  always_comb begin
    stNext    = state;
    cntNext   = cnt;
    armedNext = armed;
    unique case (state)
      ST_OFF: begin
        cntNext = cnt + CNT_W'(1);
        if (cfgLoopEn && eopSeen) begin
          stNext    = ST_REPEAT;
          cntNext   = '0;
          armedNext = 1'b0;
        end
      end
      ST_REPEAT: begin
        if (!cfgLoopEn) begin
          stNext  = ST_OFF;
          cntNext = '0;
        end else if (eopSeen) begin
          if (armed && cfgGoActive) begin
            stNext    = ST_OPEN;
            cntNext   = '0;
            armedNext = 1'b0;
          end else if (!cfgGoActive) begin
            armedNext = 1'b0;
          end
        end else if (flagSeen) begin
          armedNext = 1'b1;
        end
      end
      ST_OPEN: begin
        cntNext = cnt + CNT_W'(1);
        if (cntWrap) stNext = ST_BODY;
      end
      ST_BODY: begin
        if (bodyValid && bodyLast) begin
          stNext  = ST_CLOSE;
          cntNext = '0;
        end
      end
      ST_CLOSE: begin
        cntNext = cnt + CNT_W'(1);
        if (cntWrap) stNext = (cfgNrzi && levelMismatch) ? ST_EXTRA : leaveState;
      end
      ST_EXTRA: stNext = leaveState;
      default:  stNext = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_OFF;
      cnt   <= '0;
      armed <= 1'b0;
    end else if (bitEn) begin
      state <= stNext;
      cnt   <= cntNext;
      armed <= armedNext;
    end
  end

  assign bodyReady   = (state == ST_BODY);
  assign onLoop      = (state != ST_OFF);
  assign loopSending = (state == ST_OPEN) || (state == ST_BODY) ||
                       (state == ST_CLOSE) || (state == ST_EXTRA);
endmodule

// File: rtl/sdlc_loop_station.sv
module sdlc_loop_station
  import sdlc_loop_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic bitEn,
  input  logic rxLine,
  input  logic cfgLoopEn,
  input  logic cfgGoActive,
  input  logic cfgNrzi,
  input  logic cfgMarkIdle,
  input  logic bodyValid,
  input  logic bodyBit,
  input  logic bodyLast,
  output logic bodyReady,
  output logic txLine,
  output logic onLoop,
  output logic loopSending
);
  txStrobe_t strb;
  logic      eopSeen, flagSeen, levelMismatch;

  sdlc_loop_ctrl u_ctrl (
    .clk, .rstN, .bitEn, .cfgLoopEn, .cfgGoActive, .cfgNrzi, .cfgMarkIdle,
    .bodyValid, .bodyBit, .bodyLast, .eopSeen, .flagSeen, .levelMismatch,
    .strb, .bodyReady, .onLoop, .loopSending
  );

  sdlc_loop_dp u_dp (
    .clk, .rstN, .bitEn, .rxLine, .nrziEn(cfgNrzi), .strb,
    .txLine, .eopSeen, .flagSeen, .levelMismatch
  );
endmodule

// File: rtl/sdlc_loop_station_chk.sv
module sdlc_loop_station_chk (
  input logic clk,
  input logic rstN,
  input logic bitEn,
  input logic rxLine,
  input logic cfgLoopEn,
  input logic cfgGoActive,
  input logic cfgNrzi,
  input logic cfgMarkIdle,
  input logic bodyValid,
  input logic bodyBit,
  input logic bodyLast,
  input logic bodyReady,
  input logic txLine,
  input logic onLoop,
  input logic loopSending
);
  // R1
  repeat_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitEn && onLoop && !loopSending) |=> (txLine == $past(rxLine)));

  // R3
  sending_on_loop_chk: assert property (@(posedge clk) disable iff (!rstN)
    loopSending |-> onLoop);

  // R5
  ready_in_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    bodyReady |-> loopSending);

  // R12
  hold_between_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> ($stable(txLine) && $stable(onLoop) && $stable(loopSending)));

  // R6
  leave_needs_disable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(onLoop) |-> !$past(cfgLoopEn));

  // R7
  join_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(onLoop) |-> ($past(cfgLoopEn) && $past(bitEn)));
endmodule

bind sdlc_loop_station sdlc_loop_station_chk u_chk (.*);

// File: tb/sdlc_loop_station_test.sv
module sdlc_loop_station_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, bitEn, rxLine, cfgLoopEn, cfgGoActive, cfgNrzi, cfgMarkIdle;
  logic bodyValid, bodyBit, bodyLast;
  logic bodyReady, txLine, onLoop, loopSending;

  sdlc_loop_station uut (.*);

  int vecs = 0, bad = 0, sends = 0, extras = 0;
  bit bodyQ[$];
  // reference model state: 0 off,1 repeat,2 open,3 body,4 close,5 extra
  int mSt = 0, mCnt = 0;
  bit mTx = 1, mArmed = 0, mRxPrev = 1, lastEn = 0, lvl = 1, prevSend = 0;
  bit [7:0] mWin = 8'hFF;
  string mTag = "R11";

  task automatic check(bit ok, string req, int act, int exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit enc(bit b);
    return cfgNrzi ? (b ? mTx : !mTx) : b;
  endfunction

  task automatic step();
    bit dec, eop, flg, fb, lst;
    dec = cfgNrzi ? (rxLine == mRxPrev) : rxLine;
    mRxPrev = rxLine;
    mWin = {mWin[6:0], dec};
    eop = (mWin == 8'h7F);
    flg = (mWin == 8'h7E);
    fb = !(mCnt == 0 || mCnt == 7);
    case (mSt)
      0: begin
        mTx = enc(cfgMarkIdle ? 1'b1 : fb); mTag = "R10";
        mCnt = (mCnt + 1) % 8;
        if (cfgLoopEn && eop) begin mSt = 1; mCnt = 0; mArmed = 0; end
      end
      1: begin
        mTx = rxLine; mTag = cfgNrzi ? "R8" : "R1";
        if (!cfgLoopEn) begin mSt = 0; mCnt = 0; end
        else if (eop) begin
          if (mArmed && cfgGoActive) begin mSt = 2; mCnt = 0; mArmed = 0; end
          else if (!cfgGoActive) mArmed = 0;
        end else if (flg) mArmed = 1;
      end
      2: begin
        mTx = enc(fb); mTag = "R2";
        if (mCnt == 7) begin mSt = 3; mCnt = 0; end else mCnt++;
      end
      3: begin
        mTag = "R5";
        if (bodyQ.size() > 0) begin
          lst = (bodyQ.size() == 1);
          mTx = enc(bodyQ.pop_front());
          if (lst) begin mSt = 4; mCnt = 0; end
        end else mTx = enc(1'b1);
      end
      4: begin
        mTx = enc(fb); mTag = "R2";
        if (mCnt == 7) begin
          mCnt = 0;
          if (cfgNrzi && mTx != rxLine) begin mSt = 5; extras++; end
          else mSt = cfgLoopEn ? 1 : 0;
        end else mCnt++;
      end
      default: begin
        mTx = enc(1'b0); mTag = "R9";
        mSt = cfgLoopEn ? 1 : 0;
      end
    endcase
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mSt = 0; mCnt = 0; mTx = 1; mArmed = 0; mRxPrev = 1; mWin = 8'hFF; lastEn = 0;
    end else begin
      lastEn = bitEn;
      if (bitEn) step();
    end
  end

  always @(negedge clk) begin
    bodyValid = (bodyQ.size() > 0);
    bodyBit   = (bodyQ.size() > 0) ? bodyQ[0] : 1'b0;
    bodyLast  = (bodyQ.size() == 1);
    if (rstN) begin
      check(txLine == mTx, lastEn ? mTag : "R12", txLine, mTx);
      check(onLoop == (mSt != 0), "R6", onLoop, mSt != 0);
      check(loopSending == (mSt >= 2), "R3", loopSending, mSt >= 2);
      check(bodyReady == (mSt == 3), "R5", bodyReady, mSt == 3);
      if (loopSending && !prevSend) sends++;
      prevSend = loopSending;
    end
  end

  task automatic putBit(bit b);
    lvl = cfgNrzi ? (b ? lvl : !lvl) : b;
    @(negedge clk); rxLine = lvl; bitEn = 1'b1;
    @(negedge clk); bitEn = 1'b0;
  endtask
  task automatic putOnes(int n); for (int i = 0; i < n; i++) putBit(1'b1); endtask
  task automatic putEop(); putBit(1'b0); putOnes(7); endtask
  task automatic putFlag(); putBit(1'b0); putOnes(6); putBit(1'b0); endtask
  task automatic putRand(int n); for (int i = 0; i < n; i++) putBit(1'($urandom)); endtask
  task automatic loadBody(int n, int zeros);
    for (int i = 0; i < n; i++) bodyQ.push_back(i >= zeros);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    int s0;
    rstN = 0; bitEn = 0; rxLine = 1; cfgLoopEn = 0; cfgGoActive = 0;
    cfgNrzi = 0; cfgMarkIdle = 1; bodyValid = 0; bodyBit = 0; bodyLast = 0;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R11 reset state
    check(txLine == 1 && !onLoop && !loopSending && !bodyReady, "R11",
          {txLine, onLoop, loopSending, bodyReady}, 4'b1000);

    cfgLoopEn = 1; cfgGoActive = 1;
    putOnes(4); putEop();
    check(onLoop == 1, "R7", onLoop, 1);
    putRand(20);
    loadBody(12, 3); putFlag(); putEop(); putOnes(40);
    check(sends == 1, "R2", sends, 1);

    // R4 disarm then flag re-arms
    cfgGoActive = 0; putFlag(); putEop(); cfgGoActive = 1;
    putOnes(3); loadBody(6, 2); putEop(); putOnes(12);
    check(sends == 1, "R4", sends, 1);
    putFlag(); putEop(); putOnes(40);
    check(sends == 2, "R4", sends, 2);

    // R6 exit while sending, then idle modes
    loadBody(16, 5); putFlag(); putEop(); putOnes(12);
    cfgLoopEn = 0; putOnes(30);
    check(sends == 3 && onLoop == 0, "R6", onLoop, 0);
    cfgMarkIdle = 0; putOnes(20); cfgMarkIdle = 1; putOnes(4);

    // R6 exit while repeating
    cfgLoopEn = 1; putEop(); putRand(10);
    cfgLoopEn = 0; putBit(1'b1);
    check(onLoop == 0, "R6", onLoop, 0);

    // R6 takeover EOP and disable in the same bit time
    cfgLoopEn = 1; putEop(); putFlag(); loadBody(4, 1);
    putBit(1'b0); putOnes(6); cfgLoopEn = 0; putBit(1'b1);
    s0 = sends; putOnes(4);
    check(onLoop == 0 && sends == s0, "R6", loopSending, 0);
    bodyQ.delete();

    // R8/R9 NRZI frames with both zero parities
    cfgNrzi = 1; cfgLoopEn = 1; putOnes(3); putEop();
    for (int k = 1; k <= 4; k++) begin
      putRand(6); loadBody(10, k); putFlag(); putEop(); putOnes(36);
    end
    check(sends == 7, "R8", sends, 7);
    check(extras > 0, "R9", extras, 1);
    cfgMarkIdle = 0; cfgLoopEn = 0; putOnes(20);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule